// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Master

This block drives a three-wire serial EEPROM holding 64 sixteen-bit words. A host presents an address, a direction bit and, for writes, a data word, then pulses a start strobe. The block runs the whole exchange on its own. It selects the device, toggles the serial clock, shifts command and data bits out and shifts read data in. When the exchange is complete it pulses `done`, and for a read it presents the fetched word.

Each host request becomes a fixed sequence of frames. First comes a programming-enable command, then the read or write frame, then a programming-disable command. After a write, the block re-selects the device and keeps clocking until the data line reports ready. This busy poll is bounded by a timeout. If the timeout runs out, the block flags an error and still closes with the disable frame.

Every pin can be given opposite polarity to its logical level. This lets the block sit behind an inverting buffer stage. The returning data line is synchronised through two flops before it is used.

Top module: `mw_eeprom_master`

## Requirements
- R1: After reset `busy`, `done` and `timeout_err` are low and the chip-select, clock and data-out pins sit at their inactive level (logical 0, i.e. the pin value equals `INVERT`).
- R2: Each accepted request produces three or four frames, in this order: enable, access, (busy poll for writes), disable. Chip select is logically low between frames, and the serial clock stays low whenever chip select is low. The enable frame is the 9 bits 1,0,0,1,1,0,0,0,0 and the disable frame is the 9 bits 1,0,0,0,0,0,0,0,0, both sent MSB first.
- R3: A read frame sends 1,1,0 and then the 6 address bits MSB first. It then gives 16 more clock pulses, sampling data-in at the end of each high phase. These samples, MSB first, form `rd_data`, which is valid when `done` pulses.
- R4: A write frame sends 25 bits: 1,0,1, the 6 address bits MSB first, then the 16 data bits MSB first.
- R5: After a write frame, chip select is reasserted and clock pulses continue until data-in is sampled high. Data-in low means busy and high means ready. The disable frame follows.
- R6: If data-in is still low at the `POLL_LIMIT`-th poll sample, the poll ends and `timeout_err` pulses in the same cycle as `done`. A ready seen at exactly the `POLL_LIMIT`-th sample is a success without error. In both cases the disable frame is still sent.
- R7: `busy` is high from the cycle after an accepted start until `done`. A start arriving while `busy` is high is ignored and leaves no trace on the bus.
- R8: A start presented in the cycle where `done` is high is accepted as a new request.
- R9: Each clock phase, high or low, lasts `HALF_CYC` system clocks. Data-out changes only while the serial clock is low.
- R10: Each output pin equals its logical level XOR `INVERT`. The logical data-in equals the pin XOR `INVERT`, taken after a two-flop synchroniser.
- R11: `done` is a single-cycle pulse, given once for each accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_start | input | 1 | Start strobe for one request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Word to write |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | DATA_W | Word fetched by the last read |
| timeout_err | output | 1 | Busy poll timed out (pulses with done) |
| pin_cs | output | 1 | Chip select pin |
| pin_sck | output | 1 | Serial clock pin |
| pin_do | output | 1 | Serial data to the device |
| pin_di | input | 1 | Serial data from the device |

## Verification
Two pairs of events can land in one cycle. The first pair is the completion pulse and a new start. The bench raises the next start in the very cycle it sees `done` and expects a full second frame sequence. The second pair is the ready status and the poll timeout. The device model releases busy exactly at the last permitted poll sample, and the bench expects success with no error. One sample later, the same setup must yield `timeout_err` together with `done` and a disable frame. The bus model decodes every frame from the inverted pins, so frame order, bit content and poll length are all judged at the pins.

// File: rtl/mw_pkg.sv
package mw_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FRAME = 2'd1,
        ST_POLL  = 2'd2,
        ST_GAP   = 2'd3
    } mw_state_e;

    typedef enum logic [1:0] {
        STEP_ENABLE  = 2'd0,
        STEP_ACCESS  = 2'd1,
        STEP_BUSY    = 2'd2,
        STEP_DISABLE = 2'd3
    } mw_step_e;

    // two-bit opcode following the start bit
    localparam logic [1:0] OPC_READ    = 2'b10;
    localparam logic [1:0] OPC_WRITE   = 2'b01;
    localparam logic [1:0] OPC_SPECIAL = 2'b00;

    // top two address-field bits select the special command
    localparam logic [1:0] SUB_ENABLE  = 2'b11;
    localparam logic [1:0] SUB_DISABLE = 2'b00;

endpackage

// File: rtl/mw_half_tick.sv
module mw_half_tick #(
    parameter int HALF_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    assign tick = en && (cnt_q == LAST);

    always_comb begin
        if (!en || tick) cnt_d = '0;
        else             cnt_d = cnt_q + CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    generate
        if (HALF_CYC > 1) begin : g_spacing
            assert_tick_spacing_R9: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate
endmodule

// File: rtl/mw_din_sync.sv
module mw_din_sync #(
    parameter bit INVERT = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic bit_o
);
    logic [1:0] stg_d, stg_q;

    assign stg_d = {stg_q[0], pin_i};
    assign bit_o = stg_q[1] ^ INVERT;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= {2{INVERT}};
        else        stg_q <= stg_d;
    end
endmodule

// File: rtl/mw_pin_drive.sv
module mw_pin_drive #(
    parameter bit INVERT = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_i,
    input  logic sck_i,
    input  logic do_i,
    output logic pin_cs,
    output logic pin_sck,
    output logic pin_do
);
    logic [2:0] pins_d, pins_q;

    assign pins_d = {cs_i, sck_i, do_i} ^ {3{INVERT}};
    assign {pin_cs, pin_sck, pin_do} = pins_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pins_q <= {3{INVERT}};
        else        pins_q <= pins_d;
    end
endmodule

// File: rtl/mw_eeprom_master.sv
module mw_eeprom_master
    import mw_pkg::*;
#(
    parameter int ADDR_W     = 6,
    parameter int DATA_W     = 16,
    parameter int HALF_CYC   = 4,
    parameter int POLL_LIMIT = 32,
    parameter bit INVERT     = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_start,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic              timeout_err,
    output logic              pin_cs,
    output logic              pin_sck,
    output logic              pin_do,
    input  logic              pin_di
);
    localparam int CMD_W   = 3 + ADDR_W;
    localparam int FRAME_W = CMD_W + DATA_W;
    localparam int BL_W    = $clog2(FRAME_W + 1);
    localparam int PC_W    = $clog2(POLL_LIMIT + 1);
    localparam logic [BL_W-1:0] CMD_BL   = BL_W'(CMD_W);
    localparam logic [BL_W-1:0] FRAME_BL = BL_W'(FRAME_W);
    localparam logic [BL_W-1:0] ONE_BL   = BL_W'(1);
    localparam logic [PC_W-1:0] LAST_PC  = PC_W'(POLL_LIMIT - 1);

    typedef struct packed {
        mw_state_e         state;
        mw_step_e          step;
        logic              is_wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [FRAME_W-1:0] shreg;
        logic [BL_W-1:0]   bits_left;
        logic [DATA_W-1:0] rx;
        logic [PC_W-1:0]   poll_cnt;
        logic              cs;
        logic              sck;
        logic              dout;
        logic              done;
        logic              err;
        logic              err_pend;
        logic [DATA_W-1:0] rd_data;
    } ctl_t;

    ctl_t d, q;
    logic tick;
    logic din_s;
    logic [FRAME_W-1:0] en_vec, dis_vec, acc_vec;

    // frames are left-aligned: the MSB leaves first
    assign en_vec  = {1'b1, OPC_SPECIAL, SUB_ENABLE,  {(ADDR_W-2){1'b0}}, {DATA_W{1'b0}}};
    assign dis_vec = {1'b1, OPC_SPECIAL, SUB_DISABLE, {(ADDR_W-2){1'b0}}, {DATA_W{1'b0}}};
    assign acc_vec = q.is_wr ? {1'b1, OPC_WRITE, q.addr, q.wdata}
                             : {1'b1, OPC_READ,  q.addr, {DATA_W{1'b0}}};

    function automatic ctl_t start_frame(input ctl_t c, input logic [FRAME_W-1:0] v,
                                         input logic [BL_W-1:0] n);
        ctl_t r;
        r           = c;
        r.state     = ST_FRAME;
        r.shreg     = v;
        r.bits_left = n;
        r.cs        = 1'b1;
        r.sck       = 1'b0;
        r.dout      = v[FRAME_W-1];
        return r;
    endfunction

    mw_half_tick #(.HALF_CYC(HALF_CYC)) i_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (q.state != ST_IDLE),
        .tick  (tick)
    );

    mw_din_sync #(.INVERT(INVERT)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_i (pin_di),
        .bit_o (din_s)
    );

    mw_pin_drive #(.INVERT(INVERT)) i_pins (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_i    (q.cs),
        .sck_i   (q.sck),
        .do_i    (q.dout),
        .pin_cs  (pin_cs),
        .pin_sck (pin_sck),
        .pin_do  (pin_do)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        d.err  = 1'b0;
        unique case (q.state)
            ST_IDLE: begin
                if (req_start) begin
                    d.is_wr    = req_write;
                    d.addr     = req_addr;
                    d.wdata    = req_wdata;
                    d.err_pend = 1'b0;
                    d.step     = STEP_ENABLE;
                    d          = start_frame(d, en_vec, CMD_BL);
                end
            end
            ST_FRAME: begin
                if (tick) begin
                    if (!q.sck) begin
                        d.sck = 1'b1;
                    end else begin
                        d.sck = 1'b0;
                        d.rx  = {q.rx[DATA_W-2:0], din_s};
                        if (q.bits_left == ONE_BL) begin
                            d.cs    = 1'b0;
                            d.dout  = 1'b0;
                            d.state = ST_GAP;
                            if (q.step == STEP_ACCESS && !q.is_wr) d.rd_data = d.rx;
                        end else begin
                            d.bits_left = q.bits_left - ONE_BL;
                            d.shreg     = {q.shreg[FRAME_W-2:0], 1'b0};
                            d.dout      = q.shreg[FRAME_W-2];
                        end
                    end
                end
            end
            ST_POLL: begin
                if (tick) begin
                    if (!q.sck) begin
                        d.sck = 1'b1;
                    end else begin
                        d.sck = 1'b0;
                        if (din_s) begin
                            d.cs    = 1'b0;
                            d.state = ST_GAP;
                        end else if (q.poll_cnt == LAST_PC) begin
                            d.cs       = 1'b0;
                            d.err_pend = 1'b1;
                            d.state    = ST_GAP;
                        end else begin
                            d.poll_cnt = q.poll_cnt + PC_W'(1);
                        end
                    end
                end
            end
            ST_GAP: begin
                if (tick) begin
                    unique case (q.step)
                        STEP_ENABLE: begin
                            d.step = STEP_ACCESS;
                            d      = start_frame(d, acc_vec, FRAME_BL);
                        end
                        STEP_ACCESS: begin
                            if (q.is_wr) begin
                                d.step     = STEP_BUSY;
                                d.state    = ST_POLL;
                                d.cs       = 1'b1;
                                d.dout     = 1'b0;
                                d.poll_cnt = '0;
                            end else begin
                                d.step = STEP_DISABLE;
                                d      = start_frame(d, dis_vec, CMD_BL);
                            end
                        end
                        STEP_BUSY: begin
                            d.step = STEP_DISABLE;
                            d      = start_frame(d, dis_vec, CMD_BL);
                        end
                        STEP_DISABLE: begin
                            d.state = ST_IDLE;
                            d.done  = 1'b1;
                            d.err   = q.err_pend;
                        end
                        default: d.state = ST_IDLE;
                    endcase
                end
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy        = (q.state != ST_IDLE);
    assign done        = q.done;
    assign timeout_err = q.err;
    assign rd_data     = q.rd_data;

    assert_sck_low_when_deselected_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !q.cs |-> !q.sck);
    assert_dout_held_in_high_phase_R9: assert property (@(posedge clk) disable iff (!rst_n)
        q.sck |-> $stable(q.dout));
    assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |=> !q.done);
    assert_err_only_with_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        q.err |-> q.done);
    assert_poll_bounded_R6: assert property (@(posedge clk) disable iff (!rst_n)
        q.poll_cnt <= LAST_PC);
    assert_request_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(q.addr) && $stable(q.wdata) && $stable(q.is_wr)));
    assert_idle_pin_level_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!q.cs && $past(!q.cs)) |-> (pin_cs == INVERT));
endmodule

// File: tb/test_mw_eeprom_master.sv
module test_mw_eeprom_master;
    localparam int HALF  = 4;
    localparam int LIMIT = 12;
    localparam bit INV   = 1'b1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_start = 1'b0, req_write = 1'b0;
    logic [5:0]  req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic busy, done, timeout_err, pin_cs, pin_sck, pin_do, pin_di;
    logic [15:0] rd_data;

    always #5 clk = ~clk;

    mw_eeprom_master #(.HALF_CYC(HALF), .POLL_LIMIT(LIMIT), .INVERT(INV)) i_mw_eeprom_master (
        .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done),
        .rd_data(rd_data), .timeout_err(timeout_err), .pin_cs(pin_cs),
        .pin_sck(pin_sck), .pin_do(pin_do), .pin_di(pin_di)
    );

    // ---------------- device model, decoding logical levels ----------------
    logic cs_l, sck_l, do_l;
    logic di_l = 1'b0;
    assign cs_l   = pin_cs ^ INV;
    assign sck_l  = pin_sck ^ INV;
    assign do_l   = pin_do ^ INV;
    assign pin_di = di_l ^ INV;

    logic [15:0] mem [64];
    logic [24:0] sh = '0;
    logic [15:0] rd_word = '0;
    int  nbits = 0, poll_cnt = 0, busy_len = 3, last_poll = 0, fidx = 0;
    bit  polling = 0, pend_poll = 0, we_on = 0, reading = 0;
    int  flog [16];

    always @(posedge cs_l) begin
        nbits = 0; sh = '0; reading = 0; di_l = 1'b0;
        if (pend_poll) begin polling = 1; poll_cnt = 0; end
    end

    always @(posedge sck_l) begin
        if (cs_l) begin
            if (polling) begin
                poll_cnt++;
                di_l = (poll_cnt >= busy_len);
            end else begin
                sh = {sh[23:0], do_l};
                nbits++;
                if (nbits == 9 && sh[8:6] == 3'b110) begin
                    reading = 1; rd_word = mem[sh[5:0]];
                end
                if (reading && nbits >= 10 && nbits <= 25) di_l = rd_word[25-nbits];
            end
        end
    end

    always @(negedge cs_l) begin
        int code;
        if (polling) begin
            code = 4; last_poll = poll_cnt; polling = 0; pend_poll = 0;
        end else if (nbits == 9 && sh[8:4] == 5'b10011) begin
            code = 1; we_on = 1;
        end else if (nbits == 9 && sh[8:0] == 9'h100) begin
            code = 5; we_on = 0;
        end else if (nbits == 25 && sh[24:22] == 3'b110) begin
            code = 2;
        end else if (nbits == 25 && sh[24:22] == 3'b101) begin
            code = 3; pend_poll = 1;
            if (we_on) mem[sh[21:16]] = sh[15:0];
        end else begin
            code = 9;
        end
        if (fidx < 16) flog[fidx] = code;
        fidx++;
        di_l = 1'b0;
    end

    // ---------------- checking helpers ----------------
    int tests = 0, fails = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic check_log(input string req, input int n,
                             input int c0, input int c1, input int c2, input int c3);
        int ex [4];
        ex = '{c0, c1, c2, c3};
        check(fidx == n, req, "frame count", fidx, n);
        for (int i = 0; i < n && i < 4; i++)
            check(flog[i] == ex[i], req, "frame code", flog[i], ex[i]);
    endtask

    task automatic issue(input bit wr, input logic [5:0] a, input logic [15:0] wd);
        @(negedge clk);
        req_start = 1'b1; req_write = wr; req_addr = a; req_wdata = wd;
        @(negedge clk);
        req_start = 1'b0;
    endtask

    task automatic wait_done(output logic [15:0] rd, output bit err, output bit seen);
        seen = 0; rd = '0; err = 0;
        for (int i = 0; i < 20000 && !seen; i++) begin
            @(negedge clk);
            if (done) begin seen = 1; rd = rd_data; err = timeout_err; end
        end
    endtask

    task automatic run_op(input bit wr, input logic [5:0] a, input logic [15:0] wd,
                          output logic [15:0] rd, output bit err);
        bit seen;
        fidx = 0;
        issue(wr, a, wd);
        wait_done(rd, err, seen);
        check(seen, "R11", "done seen", seen, 1);
        @(negedge clk);
        check(done == 1'b0, "R11", "done single pulse", done, 0);
        check(busy == 1'b0, "R7", "busy after done", busy, 0);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset;
        check(busy == 1'b0, "R1", "busy", busy, 0);
        check(done == 1'b0 && timeout_err == 1'b0, "R1", "done/err", done, 0);
        check(pin_cs == INV,  "R1", "pin_cs idle",  pin_cs, INV);
        check(pin_sck == INV, "R10", "pin_sck idle", pin_sck, INV);
        check(pin_do == INV,  "R10", "pin_do idle",  pin_do, INV);
    endtask

    task automatic t_read(input logic [5:0] a);
        logic [15:0] rd; bit err;
        run_op(1'b0, a, 16'h0, rd, err);
        check(rd == mem[a], "R3", "read word", rd, mem[a]);
        check(err == 1'b0, "R3", "no error", err, 0);
        check_log("R2", 3, 1, 2, 5, 0);
    endtask

    task automatic t_write(input logic [5:0] a, input logic [15:0] wd, input int bl);
        logic [15:0] rd; bit err;
        busy_len = bl;
        run_op(1'b1, a, wd, rd, err);
        check(mem[a] == wd, "R4", "stored word", mem[a], wd);
        check_log("R5", 4, 1, 3, 4, 5);
        check(last_poll == bl, "R5", "poll pulses", last_poll, bl);
        check(err == 1'b0, "R5", "no error", err, 0);
    endtask

    task automatic t_poll_limit;
        logic [15:0] rd; bit err;
        busy_len = LIMIT;
        run_op(1'b1, 6'd9, 16'h1234, rd, err);
        check(err == 1'b0, "R6", "ready at last sample", err, 0);
        check(last_poll == LIMIT, "R6", "poll pulses at limit", last_poll, LIMIT);
        busy_len = LIMIT + 1;
        run_op(1'b1, 6'd10, 16'h4321, rd, err);
        check(err == 1'b1, "R6", "timeout flagged", err, 1);
        check(last_poll == LIMIT, "R6", "poll pulses on timeout", last_poll, LIMIT);
        check_log("R6", 4, 1, 3, 4, 5);
    endtask

    task automatic t_busy_ignore;
        logic [15:0] rd; bit err, seen;
        busy_len = 5; fidx = 0;
        issue(1'b1, 6'd20, 16'hBEEF);
        repeat (40) @(negedge clk);
        check(busy == 1'b1, "R7", "busy mid request", busy, 1);
        issue(1'b0, 6'd33, 16'h0);
        wait_done(rd, err, seen);
        check(seen, "R7", "first request done", seen, 1);
        check_log("R7", 4, 1, 3, 4, 5);
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (done || busy) begin
                check(0, "R7", "ignored start ran", 1, 0);
                break;
            end
        end
        check(fidx == 4, "R7", "no extra frames", fidx, 4);
    endtask

    task automatic t_back_to_back;
        logic [15:0] rd; bit err, seen;
        busy_len = 2; fidx = 0;
        issue(1'b0, 6'd5, 16'h0);
        wait_done(rd, err, seen);
        check(rd == mem[5], "R3", "first read", rd, mem[5]);
        // same cycle as done: present the next start
        fidx = 0;
        req_start = 1'b1; req_write = 1'b1; req_addr = 6'd6; req_wdata = 16'h7E57;
        @(negedge clk);
        req_start = 1'b0;
        check(busy == 1'b1, "R8", "start on done accepted", busy, 1);
        wait_done(rd, err, seen);
        check(seen, "R8", "second done", seen, 1);
        check(mem[6] == 16'h7E57, "R8", "second write stored", mem[6], 16'h7E57);
        check_log("R8", 4, 1, 3, 4, 5);
    endtask

    task automatic t_timing;
        logic [15:0] rd; bit err, seen;
        int hi;
        fidx = 0;
        issue(1'b0, 6'd1, 16'h0);
        @(posedge sck_l);
        hi = 0;
        @(negedge clk);
        while (sck_l) begin hi++; @(negedge clk); end
        check(hi == HALF, "R9", "clock high width", hi, HALF);
        hi = 0;
        while (!sck_l && cs_l) begin hi++; @(negedge clk); end
        check(hi == HALF, "R9", "clock low width", hi, HALF);
        wait_done(rd, err, seen);
        check(rd == mem[1], "R10", "read through inverted pins", rd, mem[1]);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = 16'hA55A ^ (16'(i) * 16'h0103);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        fidx = 0;
        t_reset();
        t_read(6'd0);
        t_read(6'd63);
        t_write(6'd17, 16'hC3A5, 3);
        t_read(6'd17);
        t_write(6'd40, 16'h0001, 1);
        t_poll_limit();
        t_busy_ignore();
        t_back_to_back();
        t_timing();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule